// File: doc/BRIEF.md
# Lock-Aware Charge-Pump Current Controller

This block sits between the reference divider, the feedback divider and the charge-pump current sources of a tuning loop. It compares the rising edges of the reference and synthesised pulse streams in a three-state phase detector and drives pump-up and pump-down strobes. While a strobe is high, it measures the strobe's length in system-clock cycles and compares that length with a programmable threshold.

In automatic mode the block picks the loop gain itself. It starts in high-current mode for fast acquisition. It moves to low-current mode for low noise once a programmable number of consecutive reference windows pass with no over-threshold error. Any error pulse longer than the threshold returns it to high current on the next clock. In manual mode software sets the current mode directly. The block also outputs the magnitude code for the active current source and the enables for three loop-filter input pins. The third pin follows high-current mode.

The pulse inputs are level signals sampled on the system clock. An edge is a sample of 1 that follows a sample of 0. No stream flows through the block, so it has no valid/ready handshake and applies no back-pressure. All control and status pins are plain levels.

Top module: `cp_lock_ctrl`

## Requirements
- R1: A reference edge ahead of a synthesised edge raises `pd_up`, and a synthesised edge ahead of a reference edge raises `pd_dn`. The strobe stays high for exactly the number of cycles between the two edges. Edges in the same cycle produce no strobe, and the two strobes are never high together.
- R2: `thr_sel` codes 0, 1, 2 and 3 set thresholds of 10, 20, 30 and 40 µs, which is 10·(code+1)·`CLK_PER_US` cycles. A strobe lasting more cycles than the threshold is a violation. A strobe of exactly the threshold is not.
- R3: In automatic mode a violation drops `low_mode` on the clock right after the strobe's first over-threshold cycle, with no settling delay.
- R4: In automatic mode `low_mode` rises only at a reference edge, and only once the number of consecutive clean reference windows reaches 1, 2, 4 or 8 for `dly_sel` codes 0 to 3. A window is clean when it holds no violation. Any violation clears the count.
- R5: If a violation falls in the same cycle as the reference edge that closes a window, that window is not counted, and the count restarts from zero.
- R6: With `auto_en` at 0, `low_mode` equals `man_low` and `locked` is 0. Lock tracking continues underneath.
- R7: With `auto_en` at 1, `locked` equals `low_mode`.
- R8: `cur_code` carries `hi_code` in high-current mode and `lo_code` zero-extended in low-current mode.
- R9: `filt_en` bit 0 enables filter input 1 and equals `filt_sel`. Bit 1 enables input 2 and equals the inverse of `filt_sel`. Bit 2 enables input 3 and is 1 exactly when `low_mode` is 0.
- R10: After reset both strobes are 0, `low_mode` and `locked` are 0 in automatic mode, and the settle count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference pulse stream |
| syn_in | input | 1 | Synthesised (divided VCO) pulse stream |
| auto_en | input | 1 | 1: lock detector chooses the current mode |
| man_low | input | 1 | Manual current mode, 1 = low current |
| thr_sel | input | 2 | Lock threshold code (10/20/30/40 µs) |
| dly_sel | input | 2 | Settling window count code (1/2/4/8) |
| hi_code | input | 3 | High-current magnitude code |
| lo_code | input | 2 | Low-current magnitude code |
| filt_sel | input | 1 | 1 selects filter input 1, 0 selects input 2 |
| pd_up | output | 1 | Pump-up strobe |
| pd_dn | output | 1 | Pump-down strobe |
| low_mode | output | 1 | 1 = low-current mode active |
| cur_code | output | 3 | Magnitude code for the active current source |
| filt_en | output | 3 | Filter input enables {in3, in2, in1} |
| locked | output | 1 | Lock indication |

## Verification
The critical overlap is a violation and a window close in the same clock. This happens when the synthesised edge leads the reference edge by exactly the threshold plus one cycle, so the pump-down strobe crosses the limit on the cycle the reference edge arrives. The bench sets up this case after one clean window has been counted. It then checks that low-current mode is not reached one window early, which shows that the coincident window was discarded and the count restarted. A violation that comes earlier in a leading strobe is also provoked, and the fall of `low_mode` is timed to the exact clock.

// File: rtl/cp_lock_pkg.sv
package cp_lock_pkg;

  // Number of selectable lock thresholds and their spacing in microseconds
  localparam int unsigned NUM_THR     = 4;
  localparam int unsigned THR_STEP_US = 10;
  localparam int unsigned THR_SEL_W   = $clog2(NUM_THR);
  localparam int unsigned DLY_SEL_W   = 2;

  // Phase detector output state
  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_UP   = 2'b01,
    PD_DN   = 2'b10
  } pd_state_e;

  // Threshold in system-clock cycles for a selector code
  function automatic int unsigned thr_cycles(input int unsigned code,
                                             input int unsigned per_us);
    return THR_STEP_US * (code + 1) * per_us;
  endfunction

endpackage

// File: rtl/cp_pfd.sv
module cp_pfd
  import cp_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic syn_in,
  output logic pd_up,
  output logic pd_dn,
  output logic ref_rise
);

  logic      ref_q, syn_q;
  logic      syn_rise;
  pd_state_e st_q, st_d;

  assign ref_rise = ref_in & ~ref_q;
  assign syn_rise = syn_in & ~syn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      syn_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      syn_q <= syn_in;
    end
  end

  // Three-state comparator: set by own edge, cleared when both are set
  always_comb begin
    logic up_n, dn_n;
    up_n = (st_q == PD_UP) | ref_rise;
    dn_n = (st_q == PD_DN) | syn_rise;
    if (up_n && dn_n)  st_d = PD_IDLE;
    else if (up_n)     st_d = PD_UP;
    else if (dn_n)     st_d = PD_DN;
    else               st_d = PD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PD_IDLE;
    else        st_q <= st_d;
  end

  assign pd_up = (st_q == PD_UP);
  assign pd_dn = (st_q == PD_DN);

endmodule

// File: rtl/cp_width_mon.sv
module cp_width_mon
  import cp_lock_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 4,
  localparam int unsigned MAX_THR   = thr_cycles(NUM_THR - 1, CLK_PER_US),
  localparam int unsigned CNT_W     = $clog2(MAX_THR + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [THR_SEL_W-1:0] thr_sel,
  output logic                 viol
);

  logic [CNT_W-1:0] lim_tab [NUM_THR];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] w_cnt;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_lim
    assign lim_tab[i] = CNT_W'(thr_cycles(i, CLK_PER_US));
  end

  assign lim = lim_tab[thr_sel];

  // Counts strobe cycles already elapsed; saturates on very long strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 w_cnt <= '0;
    else if (!active)           w_cnt <= '0;
    else if (w_cnt != {CNT_W{1'b1}}) w_cnt <= w_cnt + 1'b1;
  end

  // The cycle that makes the strobe one longer than the threshold
  assign viol = active && (w_cnt == lim);

endmodule

// File: rtl/cp_settle.sv
module cp_settle
  import cp_lock_pkg::*;
#(
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_rise,
  input  logic                 viol,
  input  logic [DLY_SEL_W-1:0] dly_sel,
  output logic                 low_state
);

  logic [SETTLE_W-1:0] good_q, good_inc, need;
  logic                dirty_q;

  assign need     = SETTLE_W'(1) << dly_sel;
  assign good_inc = (good_q == {SETTLE_W{1'b1}}) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q    <= '0;
      dirty_q   <= 1'b0;
      low_state <= 1'b0;
    end else if (viol) begin
      // Immediate fallback; a coincident window close is discarded
      good_q    <= '0;
      low_state <= 1'b0;
      dirty_q   <= ~ref_rise;
    end else if (ref_rise) begin
      dirty_q <= 1'b0;
      if (!dirty_q) begin
        good_q <= good_inc;
        if (good_inc >= need) low_state <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cp_mode_out.sv
module cp_mode_out #(
  parameter int unsigned HI_W = 3,
  parameter int unsigned LO_W = 2
) (
  input  logic            auto_en,
  input  logic            man_low,
  input  logic            low_state,
  input  logic [HI_W-1:0] hi_code,
  input  logic [LO_W-1:0] lo_code,
  input  logic            filt_sel,
  output logic            low_mode,
  output logic            locked,
  output logic [HI_W-1:0] cur_code,
  output logic [2:0]      filt_en
);

  logic [HI_W-1:0] lo_ext;

  if (LO_W < HI_W) begin : g_pad
    assign lo_ext = {{(HI_W - LO_W){1'b0}}, lo_code};
  end else begin : g_cut
    assign lo_ext = lo_code[HI_W-1:0];
  end

  assign low_mode = auto_en ? low_state : man_low;
  assign locked   = auto_en & low_state;
  assign cur_code = low_mode ? lo_ext : hi_code;
  assign filt_en  = {~low_mode, ~filt_sel, filt_sel};

endmodule

// File: rtl/cp_lock_ctrl.sv
module cp_lock_ctrl
  import cp_lock_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned SETTLE_W   = 4,
  parameter int unsigned HI_W       = 3,
  parameter int unsigned LO_W       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_in,
  input  logic                 syn_in,
  input  logic                 auto_en,
  input  logic                 man_low,
  input  logic [THR_SEL_W-1:0] thr_sel,
  input  logic [DLY_SEL_W-1:0] dly_sel,
  input  logic [HI_W-1:0]      hi_code,
  input  logic [LO_W-1:0]      lo_code,
  input  logic                 filt_sel,
  output logic                 pd_up,
  output logic                 pd_dn,
  output logic                 low_mode,
  output logic [HI_W-1:0]      cur_code,
  output logic [2:0]           filt_en,
  output logic                 locked
);

  logic ref_rise;
  logic viol;
  logic low_state;

  cp_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .syn_in   (syn_in),
    .pd_up    (pd_up),
    .pd_dn    (pd_dn),
    .ref_rise (ref_rise)
  );

  cp_width_mon #(.CLK_PER_US(CLK_PER_US)) u_width (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (pd_up | pd_dn),
    .thr_sel (thr_sel),
    .viol    (viol)
  );

  cp_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (ref_rise),
    .viol      (viol),
    .dly_sel   (dly_sel),
    .low_state (low_state)
  );

  cp_mode_out #(.HI_W(HI_W), .LO_W(LO_W)) u_out (
    .auto_en   (auto_en),
    .man_low   (man_low),
    .low_state (low_state),
    .hi_code   (hi_code),
    .lo_code   (lo_code),
    .filt_sel  (filt_sel),
    .low_mode  (low_mode),
    .locked    (locked),
    .cur_code  (cur_code),
    .filt_en   (filt_en)
  );

endmodule

// File: rtl/cp_lock_ctrl_chk.sv
module cp_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_rise,
  input logic       viol,
  input logic       auto_en,
  input logic       pd_up,
  input logic       pd_dn,
  input logic       low_mode,
  input logic       locked,
  input logic [2:0] filt_en
);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_up && pd_dn));

  a_r1_up_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_up) |-> $past(ref_rise));

  a_r3_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && auto_en) |=> (!low_mode || !auto_en));

  a_r4_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $past(auto_en) && $rose(low_mode)) |-> $past(ref_rise));

  a_r6_manual_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> !locked);

  a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |-> (locked == low_mode));

  a_r9_in3_high: assert property (@(posedge clk) disable iff (!rst_n)
    low_mode |-> !filt_en[2]);

endmodule

bind cp_lock_ctrl cp_lock_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_rise (ref_rise),
  .viol     (viol),
  .auto_en  (auto_en),
  .pd_up    (pd_up),
  .pd_dn    (pd_dn),
  .low_mode (low_mode),
  .locked   (locked),
  .filt_en  (filt_en)
);

// File: tb/tb_cp_lock_ctrl.sv
module tb_cp_lock_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int PER        = 400;
  localparam int REF_SLOT   = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, syn_in = 1'b0;
  logic       auto_en = 1'b1, man_low = 1'b0;
  logic [1:0] thr_sel = 2'd0, dly_sel = 2'd1;
  logic [2:0] hi_code = 3'd5;
  logic [1:0] lo_code = 2'd2;
  logic       filt_sel = 1'b1;
  logic       pd_up, pd_dn, low_mode, locked;
  logic [2:0] cur_code, filt_en;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_lock_ctrl #(.CLK_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .syn_in(syn_in),
    .auto_en(auto_en), .man_low(man_low), .thr_sel(thr_sel), .dly_sel(dly_sel),
    .hi_code(hi_code), .lo_code(lo_code), .filt_sel(filt_sel),
    .pd_up(pd_up), .pd_dn(pd_dn), .low_mode(low_mode), .cur_code(cur_code),
    .filt_en(filt_en), .locked(locked)
  );

  typedef struct {
    int    up_w;
    int    dn_w;
    int    low;
    int    lck;
    int    code;
    int    filt;
    int    fall;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench-side model state
  int  m_g = 0;
  int  m_low = 0;
  bit  m_dirty = 0;
  bit  chk_req = 0;
  bit  mon_en = 0;

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: computes expectations from the requirements, then plays one window
  task automatic run_period(int off, string tag);
    exp_t e;
    int thr, need, low_eff;
    bit lead_vio, lag_vio;
    thr      = 10 * (int'(thr_sel) + 1) * CPU;
    need     = 1 << dly_sel;
    lead_vio = (off < 0) && (-off > thr);
    lag_vio  = (off > 0) && (off > thr);
    e.fall   = -1;
    if (lead_vio) begin
      if (auto_en && m_low == 1) e.fall = REF_SLOT + 2 + off + thr;
      m_low = 0; m_g = 0; m_dirty = 0;
    end else begin
      if (!m_dirty) begin
        m_g = (m_g < 15) ? m_g + 1 : m_g;
        if (m_g >= need) m_low = 1;
      end
      m_dirty = 0;
    end
    if (lag_vio) begin
      if (auto_en && m_low == 1) e.fall = REF_SLOT + 2 + thr;
      m_low = 0; m_g = 0; m_dirty = 1;
    end
    low_eff = auto_en ? m_low : int'(man_low);
    e.up_w  = (off > 0) ? off : 0;
    e.dn_w  = (off < 0) ? -off : 0;
    e.low   = low_eff;
    e.lck   = (auto_en && m_low == 1) ? 1 : 0;
    e.code  = low_eff ? int'(lo_code) : int'(hi_code);
    e.filt  = {low_eff == 0, ~filt_sel, filt_sel};
    e.tag   = tag;
    exp_q.push_back(e);
    for (int s = 0; s < PER; s++) begin
      @(posedge clk); #1;
      ref_in = (s >= REF_SLOT) && (s < REF_SLOT + 2);
      syn_in = (s >= REF_SLOT + off) && (s < REF_SLOT + off + 2);
      if (s == PER - 1) chk_req = 1'b1;
    end
    @(negedge clk); #1;
  endtask

  // Monitor: measures each window at the ports and compares with the queue
  initial begin
    int up_c = 0, dn_c = 0, slot = 0, fall = -1;
    logic prev_low = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (pd_up) up_c++;
        if (pd_dn) dn_c++;
        if (slot > 0 && prev_low && !low_mode && fall < 0) fall = slot;
        prev_low = low_mode;
        slot++;
        if (chk_req) begin
          chk_req = 1'b0;
          if (exp_q.size() == 0) begin
            check("R1", "queue underflow", 0, 1);
          end else begin
            e = exp_q.pop_front();
            check("R1", {e.tag, " up width"}, up_c, e.up_w);
            check("R1", {e.tag, " dn width"}, dn_c, e.dn_w);
            check(e.tag, "low_mode", int'(low_mode), e.low);
            check("R7", {e.tag, " locked"}, int'(locked), e.lck);
            check("R8", {e.tag, " cur_code"}, int'(cur_code), e.code);
            check("R9", {e.tag, " filt_en"}, int'(filt_en), e.filt);
            check("R3", {e.tag, " fall slot"}, fall, e.fall);
          end
          up_c = 0; dn_c = 0; slot = 0; fall = -1;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "pd_up", int'(pd_up), 0);
    check("R10", "pd_dn", int'(pd_dn), 0);
    check("R10", "low_mode", int'(low_mode), 0);
    check("R10", "locked", int'(locked), 0);
    check("R10", "cur_code", int'(cur_code), 5);
    check("R10", "filt_en", int'(filt_en), 3'b101);
    #1 mon_en = 1'b1;

    // Threshold 40 cycles, two clean windows needed
    run_period(10,  "R4");
    run_period(-20, "R4");
    run_period(40,  "R2");   // exactly at threshold: no violation
    run_period(41,  "R2");   // one over: immediate fallback
    run_period(0,   "R1");   // coincident edges, dirty window not counted
    run_period(5,   "R4");
    run_period(-41, "R5");   // violation on the window-closing cycle
    run_period(3,   "R5");   // must not lock yet if R5 holds
    run_period(3,   "R4");

    // Threshold 160 cycles, eight clean windows needed
    thr_sel = 2'd3; dly_sel = 2'd3;
    run_period(100, "R2");
    run_period(161, "R3");
    for (int k = 0; k < 9; k++) run_period(-160, "R4");
    run_period(-170, "R3");  // early violation inside a leading strobe

    // Manual mode
    auto_en = 1'b0; man_low = 1'b0;
    run_period(2, "R6");
    man_low = 1'b1;
    run_period(2, "R6");

    // Back to automatic, other filter pin, short settle
    thr_sel = 2'd0; dly_sel = 2'd0; auto_en = 1'b1; filt_sel = 1'b0;
    run_period(-1, "R4");
    hi_code = 3'd7;
    run_period(50, "R3");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule